// File: doc/BRIEF.md
# Level Interrupt Storm Throttle

This block sits next to the per-pin service logic of an interrupt redirection unit. When an end-of-interrupt acknowledge finds a level-triggered pin still asserted, the service logic normally runs a new service pass at once. A handler that never clears its source can therefore keep the unit busy forever. The throttle counts these back-to-back reasserts for each pin. Once a pin's run of reasserts reaches a threshold, the block skips the immediate pass. Instead it asks for one service pass after a fixed delay, so a faulty handler still makes slow progress.

Each pin has three event inputs. The first reports a reassert: an acknowledge cleared the in-service flag, the entry is unmasked and the request is still pending. The second reports an acknowledge that found the pin masked or no longer pending. The third pulses when software writes the pin's routing entry. A timebase tick paces the deferral timer. With the tick tied high, the default delay is 10 ms of a 250 MHz clock. The block produces two outputs: a one-cycle pulse asking for an immediate service pass, and a one-cycle pulse that fires when the deferral expires. The deferred pulse covers all pins together.

Top module: `storm_throttle`

## Requirements
- R1: While reset is held and on the first cycle after it, both outputs are low. Every pin counter starts at zero and the deferral timer starts idle.
- R2: A reassert on a pin whose counter is below THRESHOLD-1 adds one to that counter. It raises `redeliver_o` for exactly the cycle after the reassert. Reasserts on several pins in the same cycle give a single pulse.
- R3: The THRESHOLD-th consecutive reassert on a pin does not raise `redeliver_o`. It returns that pin's counter to zero, so the next reassert counts as the first of a new run.
- R4: The reassert that reaches the threshold arms the timer when the timer is idle. `deferred_o` is then high for exactly one cycle, DELAY_TICKS tick cycles after the cycle of that reassert.
- R5: An idle acknowledge on `eoi_idle_i` clears that pin's counter. When it arrives in the same cycle as a reassert on the same pin, the idle acknowledge wins: the counter clears and there is no redelivery.
- R6: An entry write on `entry_wr_i` clears that pin's counter. A reassert in the same cycle on the same pin still raises `redeliver_o` and is not counted.
- R7: A threshold hit while the timer is already armed never moves the pending deadline later. The deferred pulse fires at the original deadline, and only once.
- R8: The deferral timer counts down only in cycles where `tick_i` is high. While it is low, the remaining delay holds.
- R9: Each pin keeps its own counter. Events on one pin never change the run length of another pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoi_reassert_i | input | NUM_PINS | Per pin: acknowledge found the pin unmasked and still pending |
| eoi_idle_i | input | NUM_PINS | Per pin: acknowledge found the pin masked or no longer pending |
| entry_wr_i | input | NUM_PINS | Per pin: the routing entry was written |
| tick_i | input | 1 | Timebase enable for the deferral countdown |
| redeliver_o | output | 1 | One-cycle request for an immediate service pass |
| deferred_o | output | 1 | One-cycle request for a service pass over all pins once the delay has expired |

## Verification
The bench runs a single pin through several full runs so that the immediate pulses, the skipped pulse at the threshold and the deferred pulse can each be seen at their own count. It interleaves reasserts on two pins to show that the counters are independent. It sends all pins together to show that simultaneous reasserts collapse into one pulse. Idle acknowledges and entry writes in the middle of a run, alone and in the same cycle as a reassert, show which event takes priority. Arming a second threshold hit while the timer is running, and holding the tick low during the countdown, distinguish a deadline that is kept from one that is restarted, and a timer paced by the tick from one paced by the clock.

// File: rtl/storm_pkg.sv
package storm_pkg;

    localparam int unsigned STORM_THRESHOLD_DEF = 10000;
    localparam int unsigned STORM_CLK_HZ_DEF    = 250_000_000;

    // Per-pin counter action chosen from one cycle of events
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_BUMP  = 2'd2,
        ACT_WRAP  = 2'd3
    } pin_act_e;

    typedef struct packed {
        logic now;   // immediate pass wanted
        logic late;  // threshold reached, defer
    } pin_verdict_t;

    function automatic int unsigned ticks_for(int unsigned hz, int unsigned per_second);
        return hz / per_second;
    endfunction

endpackage

// File: rtl/storm_pin_counter.sv
module storm_pin_counter
    import storm_pkg::*;
#(
    parameter int unsigned THRESHOLD = STORM_THRESHOLD_DEF,
    parameter int unsigned CNT_W     = $clog2(THRESHOLD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reassert_i,
    input  logic             idle_i,
    input  logic             wr_i,
    output pin_verdict_t     verdict_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESHOLD - 1);

    pin_act_e act;

    always_comb begin
        act = ACT_HOLD;
        if (wr_i || idle_i) begin
            act = ACT_CLEAR;
        end else if (reassert_i) begin
            act = (count_o == LAST) ? ACT_WRAP : ACT_BUMP;
        end
    end

    always_comb begin
        verdict_o.now  = (act == ACT_BUMP) || (wr_i && reassert_i && !idle_i);
        verdict_o.late = (act == ACT_WRAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else begin
            case (act)
                ACT_CLEAR, ACT_WRAP: count_o <= '0;
                ACT_BUMP:            count_o <= count_o + CNT_W'(1);
                default:             count_o <= count_o;
            endcase
        end
    end

endmodule

// File: rtl/storm_defer_timer.sv
module storm_defer_timer #(
    parameter int unsigned DELAY_TICKS = 2_500_000,
    parameter int unsigned DLY_W       = $clog2(DELAY_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             req_i,
    output logic             armed_o,
    output logic [DLY_W-1:0] rem_o,
    output logic             fire_o
);

    logic expire;

    assign expire = armed_o && tick_i && (rem_o == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_o <= 1'b0;
            rem_o   <= '0;
            fire_o  <= 1'b0;
        end else begin
            fire_o <= expire;
            if (req_i && (!armed_o || expire)) begin
                // a fixed delay is never earlier than a pending deadline,
                // so a request only arms an idle (or just-expired) timer
                armed_o <= 1'b1;
                rem_o   <= DLY_W'(DELAY_TICKS);
            end else if (expire) begin
                armed_o <= 1'b0;
                rem_o   <= '0;
            end else if (armed_o && tick_i) begin
                rem_o <= rem_o - DLY_W'(1);
            end
        end
    end

endmodule

// File: rtl/storm_throttle.sv
module storm_throttle
    import storm_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 24,
    parameter int unsigned THRESHOLD   = STORM_THRESHOLD_DEF,
    parameter int unsigned DELAY_TICKS = ticks_for(STORM_CLK_HZ_DEF, 100)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] eoi_reassert_i,
    input  logic [NUM_PINS-1:0] eoi_idle_i,
    input  logic [NUM_PINS-1:0] entry_wr_i,
    input  logic                tick_i,
    output logic                redeliver_o,
    output logic                deferred_o
);

    localparam int unsigned CNT_W = $clog2(THRESHOLD);
    localparam int unsigned DLY_W = $clog2(DELAY_TICKS + 1);

    logic [NUM_PINS-1:0]       now_vec;
    logic [NUM_PINS-1:0]       late_vec;
    logic [NUM_PINS*CNT_W-1:0] pin_cnt_flat;
    logic                      tmr_armed;
    logic [DLY_W-1:0]          tmr_rem;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_verdict_t v;
        storm_pin_counter #(
            .THRESHOLD (THRESHOLD),
            .CNT_W     (CNT_W)
        ) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .reassert_i (eoi_reassert_i[p]),
            .idle_i     (eoi_idle_i[p]),
            .wr_i       (entry_wr_i[p]),
            .verdict_o  (v),
            .count_o    (pin_cnt_flat[p*CNT_W +: CNT_W])
        );
        assign now_vec[p]  = v.now;
        assign late_vec[p] = v.late;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redeliver_o <= 1'b0;
        end else begin
            redeliver_o <= |now_vec;
        end
    end

    storm_defer_timer #(
        .DELAY_TICKS (DELAY_TICKS),
        .DLY_W       (DLY_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .req_i   (|late_vec),
        .armed_o (tmr_armed),
        .rem_o   (tmr_rem),
        .fire_o  (deferred_o)
    );

endmodule

// File: rtl/storm_throttle_chk.sv
module storm_throttle_chk #(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned CNT_W    = 14,
    parameter int unsigned DLY_W    = 22
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_PINS-1:0]       eoi_reassert_i,
    input logic [NUM_PINS-1:0]       eoi_idle_i,
    input logic [NUM_PINS-1:0]       entry_wr_i,
    input logic                      tick_i,
    input logic                      redeliver_o,
    input logic                      deferred_o,
    input logic                      armed,
    input logic [DLY_W-1:0]          rem,
    input logic [NUM_PINS*CNT_W-1:0] cnt_flat
);

    AST_REDELIVER_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        redeliver_o |-> $past(|eoi_reassert_i)); // R2

    AST_DEFER_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        deferred_o |=> !deferred_o); // R4

    AST_DEADLINE_NOT_LATER: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(armed) && !deferred_o) |-> (rem <= $past(rem))); // R7

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(armed) && !$past(tick_i)) |-> (armed && rem == $past(rem))); // R8

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            eoi_idle_i[p] |=> (cnt_flat[p*CNT_W +: CNT_W] == '0)); // R5

        AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            entry_wr_i[p] |=> (cnt_flat[p*CNT_W +: CNT_W] == '0)); // R6
    end

endmodule

bind storm_throttle storm_throttle_chk #(
    .NUM_PINS (NUM_PINS),
    .CNT_W    (CNT_W),
    .DLY_W    (DLY_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .eoi_reassert_i (eoi_reassert_i),
    .eoi_idle_i     (eoi_idle_i),
    .entry_wr_i     (entry_wr_i),
    .tick_i         (tick_i),
    .redeliver_o    (redeliver_o),
    .deferred_o     (deferred_o),
    .armed          (tmr_armed),
    .rem            (tmr_rem),
    .cnt_flat       (pin_cnt_flat)
);

// File: tb/test_storm_throttle.sv
`timescale 1ns/1ps
module test_storm_throttle;

    localparam int P   = 4;
    localparam int THR = 4;
    localparam int DLY = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [P-1:0] re   = '0;
    logic [P-1:0] idle = '0;
    logic [P-1:0] wr   = '0;
    logic         tick = 1'b1;
    logic         redeliver;
    logic         deferred;

    int errs   = 0;
    int checks = 0;

    // bench model state
    int mcnt [P];
    bit m_armed;
    int m_rem;

    always #2 clk = ~clk;

    storm_throttle #(
        .NUM_PINS    (P),
        .THRESHOLD   (THR),
        .DELAY_TICKS (DLY)
    ) i_storm_throttle (
        .clk            (clk),
        .rst            (rst),
        .eoi_reassert_i (re),
        .eoi_idle_i     (idle),
        .entry_wr_i     (wr),
        .tick_i         (tick),
        .redeliver_o    (redeliver),
        .deferred_o     (deferred)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: model the event set now on the inputs, then compare
    task automatic cycle(string tag);
        bit imm  = 0;
        bit late = 0;
        bit fire = 0;
        for (int p = 0; p < P; p++) begin
            if (wr[p]) begin
                if (re[p] && !idle[p]) imm = 1;
                mcnt[p] = 0;
            end else if (idle[p]) begin
                mcnt[p] = 0;
            end else if (re[p]) begin
                mcnt[p]++;
                if (mcnt[p] == THR) begin
                    mcnt[p] = 0;
                    late = 1;
                end else begin
                    imm = 1;
                end
            end
        end
        if (m_armed && tick) begin
            if (m_rem == 1) begin
                fire = 1;
                m_armed = 0;
            end else begin
                m_rem--;
            end
        end
        if (late && !m_armed) begin
            m_armed = 1;
            m_rem = DLY;
        end
        @(negedge clk);
        check(tag, "redeliver", redeliver, imm);
        check(tag, "deferred", deferred, fire);
        re = '0;
        idle = '0;
        wr = '0;
    endtask

    task automatic hit(logic [P-1:0] mask, string tag);
        re = mask;
        cycle(tag);
    endtask

    task automatic wait_cycles(int n, string tag);
        repeat (n) cycle(tag);
    endtask

    // run pin p forward until its next reassert would reach the threshold
    task automatic prime(int p, string tag);
        while (mcnt[p] != THR - 1) hit(P'(1) << p, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < P; p++) mcnt[p] = 0;
        m_armed = 0;
        m_rem = 0;
        repeat (3) @(negedge clk);
        check("R1", "redeliver in reset", redeliver, 1'b0);
        check("R1", "deferred in reset", deferred, 1'b0);
        rst = 1'b0;
        cycle("R1");

        // R2/R3/R4: one pin through a full run
        hit(4'b0001, "R2");
        hit(4'b0001, "R2");
        hit(4'b0001, "R2");
        hit(4'b0001, "R3");
        wait_cycles(DLY + 2, "R4");
        hit(4'b0001, "R3");

        // R9: two pins interleaved
        for (int k = 0; k < 7; k++) begin
            hit(4'b0010, "R9");
            hit(4'b0100, "R9");
        end
        wait_cycles(DLY + 2, "R9");

        // R5: idle acknowledge mid run, then together with a reassert
        for (int k = 0; k < 3; k++) hit(4'b1000, "R5");
        idle = 4'b1000;
        cycle("R5");
        for (int k = 0; k < 3; k++) hit(4'b1000, "R5");
        idle = 4'b1000;
        re = 4'b1000;
        cycle("R5");
        for (int k = 0; k < THR; k++) hit(4'b1000, "R5");
        wait_cycles(DLY + 2, "R5");

        // R6: entry write mid run, then together with a reassert
        prime(0, "R6");
        wr = 4'b0001;
        cycle("R6");
        for (int k = 0; k < 3; k++) hit(4'b0001, "R6");
        wr = 4'b0001;
        re = 4'b0001;
        cycle("R6");
        for (int k = 0; k < THR; k++) hit(4'b0001, "R6");
        wait_cycles(DLY + 2, "R6");

        // R7: second threshold hit while armed keeps the first deadline
        prime(1, "R7");
        prime(2, "R7");
        hit(4'b0010, "R7");
        wait_cycles(DLY / 2, "R7");
        hit(4'b0100, "R7");
        wait_cycles(2 * DLY, "R7");

        // R8: tick withheld, then toggling
        prime(0, "R8");
        hit(4'b0001, "R8");
        tick = 1'b0;
        wait_cycles(9, "R8");
        tick = 1'b1;
        wait_cycles(DLY + 2, "R8");
        prime(3, "R8");
        hit(4'b1000, "R8");
        for (int k = 0; k < 2 * DLY + 4; k++) begin
            tick = k[0];
            cycle("R8");
        end
        tick = 1'b1;

        // sweep: every pin through two full runs
        for (int p = 0; p < P; p++) begin
            for (int k = 0; k < 2 * THR; k++) begin
                hit(P'(1) << p, "R3");
                if (mcnt[p] == 0) wait_cycles(DLY + 1, "R4");
            end
        end

        // all pins together
        for (int k = 0; k < 2 * THR; k++) begin
            hit('1, "R2");
            wait_cycles(DLY + 1, "R2");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule